// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is the serial management port of a clock-distribution buffer. It answers on the SMBus at one fixed address and gives a host read and write access to six configuration bytes. Their contents drive the buffer's output-gating and mode logic through a flat output vector. The block samples SCL and SDA with the system clock through two-stage synchronizers. It only ever pulls SDA low, through an open-drain enable.

The first byte after the address is a command. When its top bit is set, the access is a single byte, and the low seven bits give the offset. When its top bit is clear, the access is a block that starts at offset zero. Block writes carry a count byte from the host, and the block does not use it. Block reads return a count byte before the data. After a reset the registers hold fixed defaults, and one of them is a read-only identification byte.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address 1101110, which is 0xDC with the write bit and 0xDD with the read bit. Any other address gets no acknowledge and changes nothing.
- R2: After reset, the register bytes 0 to 5 read 0x07, 0xFF, 0x00, 0x00, 0x08 and 0x00. On reg_flat, byte n sits on bits [8n+7:8n].
- R3: A byte write is address+W, then command 1ooooooo, then one data byte. It stores the data at offset ooooooo, and the slave acknowledges every byte. Data travels MSB first. Register contents change only on an SCL falling edge.
- R4: A byte read is address+W, command 1ooooooo, repeated start, address+R. The slave then returns the byte at that offset, MSB first. The slave changes SDA only while SCL is low.
- R5: A block write is address+W, then command 0x00, then a count byte, then data bytes. The data bytes are stored at offsets 0, 1, 2 and upward, and each one is acknowledged.
- R6: A block read is command 0x00, repeated start, address+R. The slave returns the count 6 first, then the bytes of offsets 0 to 5 in order, while the host acknowledges each byte.
- R7: Offset 4 is read-only. Writes to it are acknowledged, and it keeps the value 0x08.
- R8: A write to an offset of 6 or more is acknowledged and discarded. A read of such an offset returns 0x00.
- R9: A block write stopped after any complete byte keeps the bytes already sent, and the later offsets keep their values.
- R10: When the host does not acknowledge a read byte, the slave releases SDA and drives nothing until the next start. A stop condition always releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low reset, loads the register defaults |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level |
| sda_oe | output | 1 | 1 = pull SDA low |
| reg_flat | output | 8*NREG | Register bank, byte n on bits [8n+7:8n] |

## Verification
The hardest case to reach is a read that ends with a host not-acknowledge. The slave must let go of the line at exactly that point and stay silent while the host keeps clocking. The bench does a byte read and sends a not-acknowledge. It then clocks a further full byte before the stop, and samples the wired-AND line on every bit. A block write cut short after two data bytes checks that a partial transfer leaves the later offsets untouched.

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
  parameter logic [6:0] ADDR7  = 7'h6E,
  parameter int         NREG   = 6,
  parameter int         ID_IDX = 4,
  parameter logic [7:0] ID_VAL = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [8*NREG-1:0] reg_flat
);
  localparam logic [6:0] NREG7 = 7'(NREG);
  localparam logic [6:0] ID7   = 7'(ID_IDX);
  localparam logic [7:0] CNT8  = 8'(NREG);

  typedef enum logic [2:0] {IDLE, ADDR, CMD, WR, RD} st_t;

  logic [2:0] scl_sy, sda_sy;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
    end

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire scl_rise = scl_s & ~scl_sy[2];
  wire scl_fall = ~scl_s & scl_sy[2];
  wire start_c  = scl_s & scl_sy[2] & sda_sy[2] & ~sda_s;
  wire stop_c   = scl_s & scl_sy[2] & ~sda_sy[2] & sda_s;

  st_t        state;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txsh;
  logic [6:0] ptr;
  logic       cnt_pend, first_rd, sda_low;
  logic [7:0] regs [NREG];

  wire        in_bank = ptr < NREG7;
  wire [7:0]  rd_byte = !in_bank ? 8'h00 : (ptr == ID7) ? ID_VAL : regs[ptr[$clog2(NREG)-1:0]];
  wire [7:0]  tx_next = first_rd ? CNT8 : rd_byte;
  wire        wr_en   = scl_fall && !start_c && !stop_c && bitcnt == 4'd8 && state == WR &&
                        !cnt_pend && in_bank && ptr != ID7;

  function automatic logic [7:0] def_val(int i);
    if (i == 0)      return 8'h07;
    if (i == 1)      return 8'hFF;
    if (i == ID_IDX) return ID_VAL;
    return 8'h00;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= def_val(i);
    end else if (wr_en) begin
      regs[ptr[$clog2(NREG)-1:0]] <= shreg;
    end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign reg_flat[8*g +: 8] = regs[g];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      txsh     <= '0;
      ptr      <= '0;
      cnt_pend <= 1'b0;
      first_rd <= 1'b0;
      sda_low  <= 1'b0;
    end else if (start_c) begin
      state   <= ADDR;
      bitcnt  <= '0;
      sda_low <= 1'b0;
    end else if (stop_c) begin
      state   <= IDLE;
      bitcnt  <= '0;
      sda_low <= 1'b0;
    end else if (scl_rise) begin
      if (bitcnt < 4'd8) shreg <= {shreg[6:0], sda_s};
      if (bitcnt == 4'd8 && state == RD && sda_s) state <= IDLE;
      bitcnt <= bitcnt + 4'd1;
    end else if (scl_fall) begin
      if (bitcnt == 4'd8) begin
        case (state)
          ADDR:
            if (shreg[7:1] == ADDR7) begin
              sda_low <= 1'b1;
              state   <= shreg[0] ? RD : CMD;
            end else state <= IDLE;
          CMD: begin
            sda_low  <= 1'b1;
            ptr      <= shreg[7] ? shreg[6:0] : 7'd0;
            cnt_pend <= ~shreg[7];
            first_rd <= ~shreg[7];
            state    <= WR;
          end
          WR: begin
            sda_low <= 1'b1;
            if (cnt_pend) cnt_pend <= 1'b0;
            else          ptr <= ptr + 7'd1;
          end
          default: sda_low <= 1'b0;
        endcase
      end else if (bitcnt == 4'd9) begin
        bitcnt <= '0;
        if (state == RD) begin
          sda_low  <= ~tx_next[7];
          txsh     <= {tx_next[6:0], 1'b0};
          first_rd <= 1'b0;
          if (!first_rd) ptr <= ptr + 7'd1;
        end else sda_low <= 1'b0;
      end else if (state == RD && bitcnt != 4'd0) begin
        sda_low <= ~txsh[7];
        txsh    <= {txsh[6:0], 1'b0};
      end
    end

  assign sda_oe = sda_low;

  // R1
  addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_low |-> state != IDLE);
  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !sda_oe);
  // R4
  sda_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_fall && !start_c && !stop_c) |=> $stable(sda_oe));
  // R3
  reg_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_fall |=> $stable(reg_flat));
  // R7
  id_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_flat[8*ID_IDX +: 8] == ID_VAL);
  // R8
  wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (ptr < NREG7 && ptr != ID7));
endmodule

// File: tb/smb_cfg_slave_test.sv
module smb_cfg_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 6;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [8*NREG-1:0] reg_flat;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, fails = 0;
  logic [7:0] model [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_cfg_slave uut (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
                     .sda_oe(sda_oe), .reg_flat(reg_flat));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(4); scl_m = 1'b1; tick(8);
    sda_m = 1'b0; tick(8); scl_m = 1'b0; tick(4);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(4); scl_m = 1'b1; tick(8);
    sda_m = 1'b1; tick(8);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(4); scl_m = 1'b1; tick(8); scl_m = 1'b0; tick(4);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; tick(4); scl_m = 1'b1; tick(4); b = sda_line;
    tick(4); scl_m = 1'b0; tick(4);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v);
    logic b;
    for (int i = 0; i < 8; i++) begin
      recv_bit(b);
      v = {v[6:0], b};
    end
    send_bit(~mack);
  endtask

  function automatic logic [8*NREG-1:0] flat_model();
    logic [8*NREG-1:0] f;
    for (int i = 0; i < NREG; i++) f[8*i +: 8] = model[i];
    return f;
  endfunction

  task automatic byte_write(input logic [6:0] off, input logic [7:0] v, input string req);
    logic a0, a1, a2;
    bus_start;
    send_byte(8'hDC, a0); send_byte({1'b1, off}, a1); send_byte(v, a2);
    bus_stop;
    chk(a0 && a1 && a2, req, {a0, a1, a2}, 3'b111);
  endtask

  task automatic byte_read(input logic [6:0] off, input logic mack, output logic [7:0] v);
    logic a0, a1, a2;
    bus_start;
    send_byte(8'hDC, a0); send_byte({1'b1, off}, a1);
    bus_start;
    send_byte(8'hDD, a2);
    recv_byte(mack, v);
    chk(a0 && a1 && a2, "R4 read acks", {a0, a1, a2}, 3'b111);
  endtask

  task automatic t_reset;
    logic [8*NREG-1:0] e;
    e = flat_model();
    // R2
    chk(reg_flat == e, "R2 reset defaults", reg_flat, e);
    chk(sda_oe == 1'b0, "R2 idle line", sda_oe, 0);
  endtask

  task automatic t_byte_read;
    logic [7:0] v;
    byte_read(7'd0, 1'b0, v); bus_stop;
    chk(v == 8'h07, "R4 read offset0", v, 8'h07);
    byte_read(7'd1, 1'b0, v); bus_stop;
    chk(v == 8'hFF, "R4 read offset1", v, 8'hFF);
  endtask

  task automatic t_byte_write;
    logic [7:0] v;
    byte_write(7'd2, 8'hA5, "R3 write acks");
    model[2] = 8'hA5;
    chk(reg_flat == flat_model(), "R3 byte write", reg_flat, flat_model());
    byte_read(7'd2, 1'b0, v); bus_stop;
    chk(v == 8'hA5, "R3 readback", v, 8'hA5);
  endtask

  task automatic t_id_ro;
    logic [7:0] v;
    byte_write(7'd4, 8'h55, "R7 write acks");
    byte_read(7'd4, 1'b0, v); bus_stop;
    chk(v == 8'h08, "R7 id read-only", v, 8'h08);
    chk(reg_flat == flat_model(), "R7 bank unchanged", reg_flat, flat_model());
  endtask

  task automatic t_bad_addr;
    logic a0, a1;
    bus_start;
    send_byte(8'hA0, a0); send_byte(8'h81, a1); send_byte(8'h3C, a1);
    bus_stop;
    // R1
    chk(!a0, "R1 foreign address nack", a0, 0);
    chk(reg_flat == flat_model(), "R1 foreign ignored", reg_flat, flat_model());
  endtask

  task automatic t_block_write;
    logic a, all;
    bus_start;
    send_byte(8'hDC, a); all = a;
    send_byte(8'h00, a); all &= a;
    send_byte(8'h06, a); all &= a;
    for (int i = 0; i < NREG; i++) begin
      send_byte(8'h10 + 8'(i), a); all &= a;
      if (i != 4) model[i] = 8'h10 + 8'(i);
    end
    bus_stop;
    // R5
    chk(all, "R5 block acks", all, 1);
    chk(reg_flat == flat_model(), "R5 block write", reg_flat, flat_model());
  endtask

  task automatic t_block_read;
    logic a0, a1, a2;
    logic [7:0] v;
    bus_start;
    send_byte(8'hDC, a0); send_byte(8'h00, a1);
    bus_start;
    send_byte(8'hDD, a2);
    recv_byte(1'b1, v);
    // R6
    chk(v == 8'd6, "R6 count", v, 6);
    for (int i = 0; i < NREG; i++) begin
      recv_byte(i != NREG - 1, v);
      chk(v == model[i], "R6 block data", v, model[i]);
    end
    bus_stop;
    chk(a0 && a1 && a2, "R6 acks", {a0, a1, a2}, 3'b111);
  endtask

  task automatic t_out_of_range;
    logic [7:0] v;
    byte_write(7'h20, 8'h77, "R8 write acks");
    chk(reg_flat == flat_model(), "R8 discard", reg_flat, flat_model());
    byte_read(7'h20, 1'b0, v); bus_stop;
    chk(v == 8'h00, "R8 read zero", v, 0);
  endtask

  task automatic t_partial;
    logic a;
    bus_start;
    send_byte(8'hDC, a); send_byte(8'h00, a); send_byte(8'h06, a);
    send_byte(8'hC1, a); send_byte(8'hC2, a);
    bus_stop;
    model[0] = 8'hC1; model[1] = 8'hC2;
    // R9
    chk(reg_flat == flat_model(), "R9 partial block", reg_flat, flat_model());
  endtask

  task automatic t_nack;
    logic [7:0] v;
    logic b, hi;
    byte_read(7'd1, 1'b0, v);
    chk(v == model[1], "R10 data before nack", v, model[1]);
    hi = 1'b1;
    for (int i = 0; i < 9; i++) begin
      recv_bit(b);
      hi &= b;
    end
    // R10
    chk(hi, "R10 released after nack", hi, 1);
    bus_stop;
    chk(sda_oe == 1'b0, "R10 released after stop", sda_oe, 0);
  endtask

  initial begin
    model[0] = 8'h07; model[1] = 8'hFF; model[2] = 8'h00;
    model[3] = 8'h00; model[4] = 8'h08; model[5] = 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset;
    t_byte_read;
    t_byte_write;
    t_id_ro;
    t_bad_addr;
    t_block_write;
    t_block_read;
    t_out_of_range;
    t_partial;
    t_nack;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(100000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule